// File: doc/BRIEF.md
# SPI shift-clock divider with two division laws

This block derives the SPI serial clock timing from the module clock. A clock control word chooses one of two division laws: an even divide, where the SPI clock period is 2*(N+1) module clocks for an 8-bit field N, or a power-of-two divide, where the period is 2^N module clocks for a 4-bit exponent N. The block produces the serial clock level and a one-cycle enable pulse for every serial clock edge. A transfer sequencer running in the module clock domain can then shift on those pulses without a second clock domain.

A run input brackets each burst. While it is low, the block is quiet: no pulses, serial clock at its idle level, and the divide counter held at zero. It also samples the control word while idle. When run rises, counting restarts from zero, so the first half-period of every burst has its full length. Changes to the control word during a burst have no effect until the block is next idle.

Top module: `spi_clk_div`

## Requirements
- R1: After reset, tick_o and sclk_o are both 0.
- R2: In any cycle following a clock edge at which run_i was 0, tick_o is 0 and sclk_o is 0 (idle level).
- R3: The control word cfg_i decodes as follows: bits 7:0 hold the even-divide field, bits 11:8 hold the power-of-two exponent, and bit 12 selects the law (1 = even divide, 0 = power-of-two).
- R4: In even-divide mode with field N, tick_o pulses every N+1 module clocks, giving an SCLK period of 2*(N+1). N=0 gives a pulse every cycle, which is divide by 2.
- R5: In power-of-two mode with exponent N from 1 to 15, tick_o pulses every 2^(N-1) module clocks, giving an SCLK period of 2^N.
- R6: In power-of-two mode, an exponent of 0 is clamped to the fastest well-formed rate: a pulse every cycle, which is divide by 2.
- R7: sclk_o toggles exactly in the cycles in which tick_o is 1 while running. Each tick_o pulse lasts one cycle unless the half-period is one cycle.
- R8: The first tick_o of a burst appears exactly H module clocks after the first rising clock edge with run_i high, where H is the half-period. This holds even when the previous burst was stopped in mid-period.
- R9: cfg_i is sampled only at clock edges where run_i is 0. A change during a burst does not alter that burst's rate and takes effect in the next burst.
- R10: While running, the internal half-period count stays below the latched half-period length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 13 | Clock control word (fields per R3) |
| run_i | input | 1 | High for the duration of a burst |
| tick_o | output | 1 | One-cycle pulse per SCLK edge |
| sclk_o | output | 1 | Serial clock level, idle low |

## Verification
The assertions assume that run_i is driven low from reset and changes only synchronously with the module clock. They also assume that cfg_i is always a defined value. The bench drives every input on the falling clock edge and keeps run_i low through reset. It changes cfg_i mid-burst only to probe R9 and never leaves it undefined. Under these conditions the edge and idle properties can be checked against registered state from the first cycle after reset.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  typedef enum logic {
    MODE_POW2 = 1'b0,
    MODE_EVEN = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
  import spi_clk_div_pkg::*;
#(
  parameter int EVEN_W = 8,
  parameter int POW_W  = 4,
  parameter int CFG_W  = EVEN_W + POW_W + 1,
  parameter int CNT_W  = 15
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] half_o
);
  localparam int SEL_BIT = EVEN_W + POW_W;

  logic [EVEN_W-1:0] even_n;
  logic [POW_W-1:0]  pow_n;
  div_mode_e         mode;
  logic [CNT_W-1:0]  one;

  assign even_n = cfg_i[EVEN_W-1:0];
  assign pow_n  = cfg_i[SEL_BIT-1:EVEN_W];
  assign mode   = div_mode_e'(cfg_i[SEL_BIT]);
  assign one    = CNT_W'(1);

  always_comb begin
    if (mode == MODE_EVEN) begin
      half_o = CNT_W'(even_n) + one;
    end else if (pow_n == '0) begin
      // exponent 0: clamp to divide by 2
      half_o = one;
    end else begin
      half_o = one << (pow_n - POW_W'(1));
    end
  end
endmodule

// File: rtl/spi_div_counter.sv
module spi_div_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_next_i,
  output logic             wrap_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == half_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= CNT_W'(1);
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      half_q <= half_next_i;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= wrap_o;
      cnt_q  <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < half_q);

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) && run_i |-> $stable(half_q));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wrap_i,
  output logic sclk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sclk_o <= 1'b0;
    else if (!run_i)  sclk_o <= 1'b0;
    else if (wrap_i)  sclk_o <= ~sclk_o;
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int EVEN_W = 8,
  parameter int POW_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [EVEN_W+POW_W:0]     cfg_i,
  input  logic                      run_i,
  output logic                      tick_o,
  output logic                      sclk_o
);
  localparam int CFG_W    = EVEN_W + POW_W + 1;
  localparam int POW_MAXW = (1 << POW_W) - 1;
  localparam int CNT_W    = (POW_MAXW > EVEN_W + 1) ? POW_MAXW : EVEN_W + 1;

  logic [CNT_W-1:0] half_next;
  logic             wrap;

  spi_cfg_decode #(
    .EVEN_W(EVEN_W), .POW_W(POW_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
  ) u_dec (
    .cfg_i (cfg_i),
    .half_o(half_next)
  );

  spi_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .half_next_i(half_next),
    .wrap_o     (wrap),
    .tick_o     (tick_o)
  );

  spi_sclk_gen u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .wrap_i(wrap),
    .sclk_o(sclk_o)
  );

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o && !sclk_o);

  p_edge_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> (tick_o == (sclk_o != $past(sclk_o))));
endmodule

// File: tb/tb_spi_clk_div.sv
module tb_spi_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cfg = '0;
  logic        run = 1'b0;
  logic        tick, sclk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int  m_half = 1, m_cnt = 0;
  bit  m_tick = 0, m_sclk = 0;

  always #2 clk = ~clk; // 250 MHz

  spi_clk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .run_i(run),
    .tick_o(tick), .sclk_o(sclk)
  );

  function automatic int exp_half(logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    if (c[11:8] == 0) return 1;
    return 1 << (int'(c[11:8]) - 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_half = 1; m_cnt = 0; m_tick = 0; m_sclk = 0;
    end else if (!run) begin
      m_half = exp_half(cfg); m_cnt = 0; m_tick = 0; m_sclk = 0;
    end else if (m_cnt == m_half - 1) begin
      m_cnt = 0; m_tick = 1; m_sclk = !m_sclk;
    end else begin
      m_cnt++; m_tick = 0;
    end
  end

  // per-cycle model comparison (R7 tick/sclk relation, R2 idle)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(tick == m_tick, "R7 tick vs model", int'(tick), int'(m_tick));
      check(sclk == m_sclk, "R7 sclk vs model", int'(sclk), int'(m_sclk));
    end
    if (cyc > 190000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // measure gaps between ticks for a burst of n ticks
  task automatic burst(logic [12:0] c, int n, int h, string req);
    int gap;
    cfg = c;
    repeat (2) @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < n; k++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!tick && gap < h + 4);
      check(gap == h, k == 0 ? "R8 first half-period" : req, gap, h);
    end
    run = 1'b0;
    @(negedge clk);
    check(!tick && !sclk, "R2 idle after burst", int'({tick, sclk}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!tick && !sclk, "R1 reset state", int'({tick, sclk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tick && !sclk, "R1 after release", int'({tick, sclk}), 0);

    // even mode, R3 select bit 12 = 1, field bits 7:0
    burst(13'h1_F00, 4, 1,   "R4 even N=0");
    burst(13'h1_503, 4, 4,   "R4 even N=3");
    burst(13'h1_0FF, 3, 256, "R4 even N=255");
    // power-of-two mode, R3 exponent bits 11:8, even field ignored
    burst(13'h0_1AB, 4, 1,    "R5 pow N=1");
    burst(13'h0_4FF, 4, 8,    "R5 pow N=4 R3");
    burst(13'h0_A00, 3, 512,  "R5 pow N=10");
    burst(13'h0_F00, 2, 16384,"R5 pow N=15");
    burst(13'h0_07F, 6, 1,    "R6 pow N=0 clamp");

    // R9: change cfg mid-burst, rate must not change
    begin
      int gap;
      cfg = 13'h1_002;                 // half 3
      repeat (2) @(negedge clk);
      run = 1'b1;
      repeat (2) @(negedge clk);
      cfg = 13'h1_009;                 // half 10, ignored now
      for (int k = 0; k < 4; k++) begin
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick && gap < 20);
        if (k > 0) check(gap == 3, "R9 mid-burst cfg ignored", gap, 3);
      end
      // R8: stop in mid-period, restart must give full first half
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      check(!sclk, "R2 idle level", int'(sclk), 0);
      run = 1'b1;
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick && gap < 20);
      check(gap == 10, "R9 new cfg after idle R8 restart", gap, 10);
      run = 1'b0;
      @(negedge clk);
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule